// File: doc/BRIEF.md
# Block-Based Pattern Program Sequencer

This block runs a small stored program that decides in which order stretches of pattern memory are played out. Each program line points at a block of pattern memory (a start address and a length) and adds control: how many times to play it, an event to wait for before the first word, a level for one chosen inter-module signal, a conditional jump taken when the last pass ends, and flags for calling a sub-sequence, returning from one, or ending the program. While a block plays, the sequencer puts one pattern address per cycle on its output together with a valid strobe. The pattern memory itself and the analog output stage sit outside.

Software writes the program through a simple write port while `run` is low. Raising `run` starts execution at line 0. Dropping it aborts at once and returns the block to idle. A manual step mode lets an operator satisfy wait and jump conditions by hand, so that the program flow can be debugged one condition at a time.

Top module: `blkseq`

## Requirements
- R1: After reset, and whenever `run` is low, `pat_valid`, `done` and `err` are 0 and `sig_o` is 4'b0000. Raising `run` starts execution at line 0.
- R2: A program line is an 84-bit word (default parameters). Its block start is bits [11:0] and its length minus one is bits [23:12]. The line emits consecutive addresses from the start on consecutive cycles with `pat_valid` high, and nothing else is emitted.
- R3: Bits [39:24] hold the repeat count minus one, so a block plays 1 to 65,536 times. Bit 40 set makes the block repeat until `run` drops.
- R4: Before its first word, a line holds `pat_valid` low until `((ev_in ^ wval) & wmask) == 0`, where wmask is bits [48:41] and wval is bits [56:49]. A wmask of zero means no wait.
- R5: When the last word of the last pass is emitted, the line jumps to target line bits [79:74] if jump-enable bit 57 is set and `((ev_in ^ jval) & jmask) == 0`, where jmask is bits [65:58] and jval is bits [73:66]. A zero jmask makes the jump unconditional. Otherwise execution continues at the next line.
- R6: A line with end bit 83 set, whose jump is not taken, halts after its block: `done` goes high and `pat_valid` stays low.
- R7: `sig_o` has at most one bit set. Bit `sig_sel` carries the level bit 80 of the line that is playing, from its first word on.
- R8: A line with call bit 81 set plays no pattern. It continues at the target line and stores the following line number. When a line with return bit 82 completes inside the sub-sequence, execution resumes at the stored line.
- R9: A call reached while a sub-sequence is already active sets `err` and stops output until `run` drops.
- R10: With `step_mode` high, every wait or jump condition with a nonzero mask is satisfied by the `step_in` level, and `ev_in` is ignored.
- R11: Dropping `run` aborts at the next edge. The block then emits no words and clears `done` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pattern clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Program write strobe |
| wr_addr | input | 6 | Program line to write |
| wr_data | input | 84 | Program line contents |
| ev_in | input | 8 | External event inputs |
| run | input | 1 | Execute when high, abort and idle when low |
| step_mode | input | 1 | Manual condition mode |
| step_in | input | 1 | Manual condition level |
| sig_sel | input | 2 | Which inter-module signal the program drives |
| pat_addr | output | 12 | Pattern memory read address |
| pat_valid | output | 1 | Address is a live pattern word |
| sig_o | output | 4 | Inter-module signal lines |
| done | output | 1 | Program reached its end line |
| err | output | 1 | Nested sub-sequence call detected |

## Verification
The hardest states to reach are a line parked on its wait condition with a sub-sequence call still open, and a jump whose outcome a manual step decides rather than an event. The bench gets there by starting the program with the wait event absent. It lets the queue of expected words drain, confirms that the output stays silent for several cycles, and only then supplies the event or the step level. An unconditional backward jump and an endlessly repeated block are cut off by dropping `run` right after the last expected word, which shows that the abort takes effect at the next edge.

// File: rtl/blkseq.sv
module blkseq #(
  parameter int LINES = 64,
  parameter int AW = 12,
  parameter int RW = 16,
  localparam int TW = $clog2(LINES),
  localparam int LW = 2*AW + RW + TW + 38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_addr,
  input  logic [LW-1:0] wr_data,
  input  logic [7:0]    ev_in,
  input  logic          run,
  input  logic          step_mode,
  input  logic          step_in,
  input  logic [1:0]    sig_sel,
  output logic [AW-1:0] pat_addr,
  output logic          pat_valid,
  output logic [3:0]    sig_o,
  output logic          done,
  output logic          err
);
  localparam int P_LEN = AW;
  localparam int P_REP = 2*AW;
  localparam int P_INF = P_REP + RW;
  localparam int P_WM  = P_INF + 1;
  localparam int P_WV  = P_WM + 8;
  localparam int P_JEN = P_WV + 8;
  localparam int P_JM  = P_JEN + 1;
  localparam int P_JV  = P_JM + 8;
  localparam int P_TGT = P_JV + 8;
  localparam int P_LVL = P_TGT + TW;
  localparam int P_CALL = P_LVL + 1;
  localparam int P_RET = P_LVL + 2;
  localparam int P_EOP = P_LVL + 3;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_EMIT, S_HALT, S_ERR} st_t;

  st_t st;
  logic [LW-1:0] prog [LINES];
  logic [TW-1:0] pc, ret_pc;
  logic [AW-1:0] off;
  logic [RW-1:0] rep;
  logic in_sub, lvl;

  always_ff @(posedge clk)
    if (wr_en) prog[wr_addr] <= wr_data;

  wire [LW-1:0] cur   = prog[pc];
  wire [AW-1:0] c_st  = cur[AW-1:0];
  wire [AW-1:0] c_len = cur[P_LEN +: AW];
  wire [RW-1:0] c_rep = cur[P_REP +: RW];
  wire [7:0]    c_wm  = cur[P_WM +: 8];
  wire [7:0]    c_wv  = cur[P_WV +: 8];
  wire [7:0]    c_jm  = cur[P_JM +: 8];
  wire [7:0]    c_jv  = cur[P_JV +: 8];
  wire [TW-1:0] c_tgt = cur[P_TGT +: TW];

  wire w_ok = (c_wm == 8'd0) | (step_mode ? step_in : (((ev_in ^ c_wv) & c_wm) == 8'd0));
  wire j_ok = cur[P_JEN] & ((c_jm == 8'd0) | (step_mode ? step_in : (((ev_in ^ c_jv) & c_jm) == 8'd0)));
  wire last_word = (off == c_len);
  wire last_pass = !cur[P_INF] && (rep == c_rep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; ret_pc <= '0; off <= '0; rep <= '0; in_sub <= 1'b0; lvl <= 1'b0;
    end else if (!run) begin
      st <= S_IDLE; pc <= '0; off <= '0; rep <= '0; in_sub <= 1'b0; lvl <= 1'b0;
    end else begin
      case (st)
        S_IDLE: st <= S_WAIT;
        S_WAIT:
          if (cur[P_CALL]) begin
            if (in_sub) st <= S_ERR;
            else begin
              ret_pc <= pc + 1'b1;
              in_sub <= 1'b1;
              pc <= c_tgt;
            end
          end else if (w_ok) begin
            st <= S_EMIT; off <= '0; rep <= '0; lvl <= cur[P_LVL];
          end
        S_EMIT:
          if (!last_word) off <= off + 1'b1;
          else begin
            off <= '0;
            if (!last_pass) rep <= rep + 1'b1;
            else begin
              rep <= '0;
              if (j_ok) begin
                pc <= c_tgt; st <= S_WAIT;
              end else if (cur[P_EOP]) st <= S_HALT;
              else if (cur[P_RET] && in_sub) begin
                pc <= ret_pc; in_sub <= 1'b0; st <= S_WAIT;
              end else begin
                pc <= pc + 1'b1; st <= S_WAIT;
              end
            end
          end
        default: st <= st;
      endcase
    end
  end

  assign pat_valid = (st == S_EMIT);
  assign pat_addr  = c_st + off;
  assign done      = (st == S_HALT);
  assign err       = (st == S_ERR);
  assign sig_o     = lvl ? (4'b0001 << sig_sel) : 4'b0000;

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pat_valid && !done && !err));
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && run && !last_word) |=> (pat_valid && pat_addr == $past(pat_addr) + 1'b1));
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && run) |=> err);
  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pat_valid);
  p_one_sig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sig_o));
endmodule

// File: tb/blkseq_tb.sv
module blkseq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic wr_en = 0, run = 0, step_mode = 0, step_in = 0;
  logic [5:0] wr_addr = '0;
  logic [83:0] wr_data = '0;
  logic [7:0] ev_in = '0;
  logic [1:0] sig_sel = 2'd2;
  logic [11:0] pat_addr;
  logic pat_valid, done, err;
  logic [3:0] sig_o;

  blkseq dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_in(ev_in), .run(run), .step_mode(step_mode), .step_in(step_in), .sig_sel(sig_sel),
    .pat_addr(pat_addr), .pat_valid(pat_valid), .sig_o(sig_o), .done(done), .err(err));

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  string tag_q[$];

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [83:0] mk(logic [11:0] st, logic [11:0] lm1, logic [15:0] rm1, logic inf,
      logic [7:0] wm, logic [7:0] wv, logic jen, logic [7:0] jm, logic [7:0] jv, logic [5:0] tgt,
      logic lvl, logic call, logic ret, logic eop);
    logic [83:0] w;
    w = '0;
    w[11:0] = st; w[23:12] = lm1; w[39:24] = rm1; w[40] = inf;
    w[48:41] = wm; w[56:49] = wv; w[57] = jen; w[65:58] = jm; w[73:66] = jv;
    w[79:74] = tgt; w[80] = lvl; w[81] = call; w[82] = ret; w[83] = eop;
    return w;
  endfunction

  task automatic wr(int a, logic [83:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a[5:0]; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic push(int base, int n, int reps, string tag);
    for (int r = 0; r < reps; r++)
      for (int i = 0; i < n; i++) begin exp_q.push_back(base + i); tag_q.push_back(tag); end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) begin @(negedge clk); #1; end
  endtask

  task automatic wait_end();
    while (!(done || err)) @(negedge clk);
    #1;
  endtask

  task automatic stop();
    @(negedge clk); run = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load_a();
    wr(0, mk(12'h100, 2, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0));
    wr(1, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 5, 0, 1, 0, 0));
    wr(2, mk(12'h200, 0, 0, 0, 0, 0, 1, 8'h01, 8'h01, 4, 0, 0, 0, 0));
    wr(3, mk(12'h300, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    wr(4, mk(12'h400, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    wr(5, mk(12'h500, 1, 2, 0, 8'h80, 8'h80, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(6, mk(12'h600, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
  endtask

  always @(negedge clk) begin
    if (rst_n && pat_valid) begin
      if (exp_q.size() == 0) chk(0, "R2", "unexpected word", pat_addr, 0);
      else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(pat_addr == e[11:0], t, "address", pat_addr, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R11 watchdog expired: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!pat_valid && !done && !err, "R1", "idle flags", {pat_valid, done, err}, 0);
    chk(sig_o == 4'b0000, "R1", "idle signals", sig_o, 0);

    load_a();
    ev_in = 8'h80;
    push(12'h100, 3, 2, "R3"); push(12'h500, 2, 3, "R8"); push(12'h600, 1, 1, "R8");
    push(12'h200, 1, 1, "R5"); push(12'h300, 2, 1, "R6");
    @(negedge clk); run = 1;
    while (!pat_valid) @(negedge clk);
    chk(sig_o == 4'b0100, "R7", "selected signal", sig_o, 4'b0100);
    wait_end();
    chk(done == 1'b1, "R6", "done", done, 1);
    chk(exp_q.size() == 0, "R2", "words left", exp_q.size(), 0);
    chk(sig_o == 4'b0000, "R7", "signal after low line", sig_o, 0);
    stop();
    chk(done == 1'b0, "R11", "done cleared", done, 0);

    ev_in = 8'h81;
    push(12'h100, 3, 2, "R3"); push(12'h500, 2, 3, "R8"); push(12'h600, 1, 1, "R8");
    push(12'h200, 1, 1, "R5"); push(12'h400, 1, 1, "R5");
    @(negedge clk); run = 1;
    wait_end();
    chk(done && exp_q.size() == 0, "R5", "jump path complete", exp_q.size(), 0);
    stop();

    ev_in = 8'h00;
    push(12'h100, 3, 2, "R2");
    @(negedge clk); run = 1;
    drain();
    repeat (8) @(negedge clk);
    chk(pat_valid == 1'b0, "R4", "held on wait", pat_valid, 0);
    push(12'h500, 2, 3, "R4"); push(12'h600, 1, 1, "R8");
    push(12'h200, 1, 1, "R5"); push(12'h300, 2, 1, "R6");
    ev_in = 8'h80;
    wait_end();
    chk(done && exp_q.size() == 0, "R4", "resumed after event", exp_q.size(), 0);
    stop();

    ev_in = 8'h00; step_mode = 1; step_in = 0;
    push(12'h100, 3, 2, "R10");
    @(negedge clk); run = 1;
    drain();
    repeat (6) @(negedge clk);
    chk(pat_valid == 1'b0, "R10", "step wait held", pat_valid, 0);
    push(12'h500, 2, 3, "R10"); push(12'h600, 1, 1, "R10");
    push(12'h200, 1, 1, "R10"); push(12'h400, 1, 1, "R10");
    step_in = 1;
    wait_end();
    chk(done && exp_q.size() == 0, "R10", "step path complete", exp_q.size(), 0);
    stop();
    step_mode = 0; step_in = 0;

    wr(0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 1, 0, 0));
    wr(1, mk(12'h700, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    wr(2, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 1, 0, 0));
    wr(3, mk(12'h710, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0));
    @(negedge clk); run = 1;
    wait_end();
    chk(err == 1'b1, "R9", "nested call error", err, 1);
    chk(pat_valid == 1'b0, "R9", "no output on error", pat_valid, 0);
    stop();
    chk(err == 1'b0, "R11", "error cleared", err, 0);

    wr(0, mk(12'h010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(1, mk(12'h020, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(2, mk(12'h030, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0));
    push(12'h010, 1, 1, "R5");
    for (int k = 0; k < 3; k++) begin push(12'h020, 1, 1, "R5"); push(12'h030, 1, 1, "R5"); end
    @(negedge clk); run = 1;
    drain();
    run = 0;
    repeat (3) @(negedge clk);
    chk(pat_valid == 1'b0 && exp_q.size() == 0, "R11", "abort after loop", pat_valid, 0);

    wr(0, mk(12'h040, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    push(12'h040, 2, 25, "R3");
    @(negedge clk); run = 1;
    drain();
    run = 0;
    repeat (3) @(negedge clk);
    chk(pat_valid == 1'b0 && !done, "R3", "endless block stopped", pat_valid, 0);

    wr(0, mk(12'h070, 0, 299, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    push(12'h070, 1, 300, "R3");
    @(negedge clk); run = 1;
    wait_end();
    chk(done && exp_q.size() == 0, "R3", "300 passes", exp_q.size(), 0);
    stop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule